// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit register interface. Software arms it, feeds it and reconfigures it only by writing magic values to a key register. Configuration of the clock divider, the 12-bit reload value and the early-warning compare is refused unless the most recent key written was the unlock key. Once started, the watchdog runs until the block is reset. If a full reload period passes without a feed, it emits a one-cycle system-reset pulse.

The counter side is modelled in the bus clock domain. The crossing into a slower counter clock is replaced by a fixed, parameterised update latency. During that latency a per-field busy flag in the status word stays set, and the new value is not yet in use. An early-warning flag rises when the down-counter passes the compare value, and it drives the interrupt output when enabled. It can be acknowledged while the registers are locked, and acknowledging it that way does not feed the counter.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the status word (0x0C) reads 0, the divider field (0x04) reads 0, the reload field (0x08) reads 0xFFF, the early-warning word (0x14) reads 0, and both outputs are low.
- R2: A key write (0x00, value in bits 15:0) of 0x5555 unlocks configuration, and any other key value relocks it. While locked, writes to 0x04, 0x08 and 0x14 leave their read-back values and the busy flags unchanged.
- R3: An accepted write to 0x04 sets status bit 0, to 0x08 sets bit 1, and to 0x14 sets bits 2 and 3. Each flag reads 1 for SYNC_LAT cycles and then clears. The new value is used by the counter only once its flag has cleared.
- R4: Key 0xCCCC starts the watchdog and loads the counter, after which status bit 8 reads 1. No register write clears bit 8; only the block reset does.
- R5: While running, the counter decrements once every D cycles, where D = 2^(code+2) for divider codes 0..8 and codes above 8 act as 8. A tick taken at zero issues a one-cycle pulse on `wdg_reset_pulse` (R+1)*D cycles after the counter was loaded with R, then reloads R and keeps counting.
- R6: Key 0xAAAA reloads the counter from the reload value and restarts the divider phase.
- R7: Status bit 15 sets when the counter decrements to the compare value (0x14 bits 11:0). `wdg_irq` is high while that flag is set and the enable (0x14 bit 15) is in effect.
- R8: An accepted write to 0x14 also feeds the counter, in the same way as key 0xAAAA.
- R9: While locked, a write to 0x14 only acts on bit 14 (write 1 clears the early-warning flag). It does not feed the counter and it changes neither compare nor enable.
- R10: Writing 1 to bit 15 of 0x18 clears the early-warning flag whether locked or not.
- R11: Reads of 0x00 and 0x18 return 0, and 0x3F4 returns revision 0x40 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low block reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdg_irq | output | 1 | Early-warning interrupt |
| wdg_reset_pulse | output | 1 | One-cycle system-reset request |

## Verification
The bench measures the exact cycle distance from start or feed to the early-warning interrupt and to the reset pulse, across divider codes that include an out-of-range code. A design that miscounts the divider phase or the zero tick shifts these distances. The bench also writes a new reload value and starts the counter while that value is still busy. A design that applied the value at once would expire far too early. The locked acknowledge path is checked for a feed that should not happen, which would move the next pulse. The relock-by-any-key rule and the unstoppable running state are also covered, since a leaky key decoder would accept writes or stop the watchdog.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned KEY_W  = 16;
  localparam int unsigned NSLOT  = 4;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_KEY  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PRE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RLD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EWC  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ICLR = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_VER  = 12'h3F4;

  // key values
  localparam logic [KEY_W-1:0] KEY_LOCK = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_FEED = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_GO   = 16'hCCCC;

  // bit positions
  localparam int unsigned EW_EN_BIT    = 15;
  localparam int unsigned EW_CLR_BIT   = 14;
  localparam int unsigned ICLR_BIT     = 15;
  localparam int unsigned STAT_RUN_BIT = 8;
  localparam int unsigned STAT_EW_BIT  = 15;

  // busy slot indices (status bits 0..3)
  localparam int unsigned SLOT_PRE = 0;
  localparam int unsigned SLOT_RLD = 1;
  localparam int unsigned SLOT_CMP = 2;
  localparam int unsigned SLOT_EN  = 3;

  typedef enum logic [2:0] {
    K_OPEN,
    K_FEED,
    K_GO,
    K_LOCK,
    K_OTHER
  } key_act_e;

  function automatic key_act_e kwd_decode_key(input logic [KEY_W-1:0] k);
    case (k)
      KEY_OPEN: return K_OPEN;
      KEY_FEED: return K_FEED;
      KEY_GO:   return K_GO;
      KEY_LOCK: return K_LOCK;
      default:  return K_OTHER;
    endcase
  endfunction

  // log2 of the divider: code + 2, saturated at max_code + 2
  function automatic int unsigned kwd_div_shift(input logic [7:0] code,
                                                input int unsigned max_code);
    int unsigned c;
    c = 32'(code);
    if (c > max_code) c = max_code;
    return c + 2;
  endfunction

  function automatic logic [31:0] kwd_status_word(input logic [NSLOT-1:0] busy,
                                                  input logic run,
                                                  input logic flag);
    logic [31:0] w;
    w = '0;
    w[NSLOT-1:0]   = busy;
    w[STAT_RUN_BIT] = run;
    w[STAT_EW_BIT]  = flag;
    return w;
  endfunction

endpackage

// File: rtl/kwd_sync_slot.sv
module kwd_sync_slot #(
  parameter int unsigned LAT   = 5,
  parameter int unsigned LAT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done
);

  logic [LAT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (load)          left_q <= LAT_W'(LAT);
    else if (left_q != '0)  left_q <= left_q - LAT_W'(1);
  end

  assign busy = (left_q != '0);
  assign done = (left_q == LAT_W'(1)) && !load;

  // R3: a write raises its flag on the next cycle
  a_r3_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R3: the flag drops right after the value is handed over
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/kwd_regfile.sv
module kwd_regfile
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PRE_W    = 4,
  parameter int unsigned SYNC_LAT = 5,
  parameter logic [7:0]  REV      = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              running,
  input  logic              ew_flag,
  output logic [PRE_W-1:0]  pre_eff,
  output logic [CNT_W-1:0]  rld_eff,
  output logic [CNT_W-1:0]  cmp_eff,
  output logic              en_eff,
  output logic              feed_evt,
  output logic              go_evt,
  output logic              clr_evt
);

  localparam int unsigned LAT_W = $clog2(SYNC_LAT + 1);

  logic             unlocked_q;
  logic [PRE_W-1:0] pre_sh;
  logic [CNT_W-1:0] rld_sh, cmp_sh;
  logic             en_sh;
  key_act_e         key_act;
  logic             key_hit, pre_wr, rld_wr, ewc_hit, ewc_wr, iclr_hit;
  logic [NSLOT-1:0] slot_load, slot_busy, slot_done;
  logic             unused_hi;

  assign unused_hi = ^wdata[31:16];

  // key and write-enable decoding
  assign key_act  = kwd_decode_key(wdata[KEY_W-1:0]);
  assign key_hit  = wr_en && (addr == OFS_KEY);
  assign pre_wr   = wr_en && (addr == OFS_PRE) && unlocked_q;
  assign rld_wr   = wr_en && (addr == OFS_RLD) && unlocked_q;
  assign ewc_hit  = wr_en && (addr == OFS_EWC);
  assign ewc_wr   = ewc_hit && unlocked_q;
  assign iclr_hit = wr_en && (addr == OFS_ICLR);

  assign go_evt   = key_hit && (key_act == K_GO);
  assign feed_evt = (key_hit && (key_act == K_FEED)) || ewc_wr;
  assign clr_evt  = (ewc_hit && wdata[EW_CLR_BIT]) || (iclr_hit && wdata[ICLR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked_q <= 1'b0;
    else if (key_hit) unlocked_q <= (key_act == K_OPEN);
  end

  // shadow copies, as software wrote them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sh <= '0;
      rld_sh <= '1;
      cmp_sh <= '0;
      en_sh  <= 1'b0;
    end else begin
      if (pre_wr) pre_sh <= wdata[PRE_W-1:0];
      if (rld_wr) rld_sh <= wdata[CNT_W-1:0];
      if (ewc_wr) begin
        cmp_sh <= wdata[CNT_W-1:0];
        en_sh  <= wdata[EW_EN_BIT];
      end
    end
  end

  // update latency trackers
  assign slot_load[SLOT_PRE] = pre_wr;
  assign slot_load[SLOT_RLD] = rld_wr;
  assign slot_load[SLOT_CMP] = ewc_wr;
  assign slot_load[SLOT_EN]  = ewc_wr;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    kwd_sync_slot #(
      .LAT   (SYNC_LAT),
      .LAT_W (LAT_W)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (slot_load[i]),
      .busy  (slot_busy[i]),
      .done  (slot_done[i])
    );
  end

  // values the counter side uses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_eff <= '0;
      rld_eff <= '1;
      cmp_eff <= '0;
      en_eff  <= 1'b0;
    end else begin
      if (slot_done[SLOT_PRE]) pre_eff <= pre_sh;
      if (slot_done[SLOT_RLD]) rld_eff <= rld_sh;
      if (slot_done[SLOT_CMP]) cmp_eff <= cmp_sh;
      if (slot_done[SLOT_EN])  en_eff  <= en_sh;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_PRE:  rdata = 32'(pre_sh);
      OFS_RLD:  rdata = 32'(rld_sh);
      OFS_STAT: rdata = kwd_status_word(slot_busy, running, ew_flag);
      OFS_EWC: begin
        rdata[CNT_W-1:0] = cmp_sh;
        rdata[EW_EN_BIT] = en_sh;
      end
      OFS_VER:  rdata = 32'(REV);
      default:  rdata = '0;
    endcase
  end

  // R2: a locked divider write changes nothing
  a_r2_locked_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PRE && !unlocked_q) |=> $stable(pre_sh));

  // R9: a locked early-warning write keeps compare and enable
  a_r9_locked_ewc: assert property (@(posedge clk) disable iff (!rst_n)
    (ewc_hit && !unlocked_q) |=> ($stable(cmp_sh) && $stable(en_sh)));

  // R2: a non-unlock key leaves the registers locked
  a_r2_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && key_act != K_OPEN) |=> !unlocked_q);

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PRE_W    = 4,
  parameter int unsigned MAX_CODE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_evt,
  input  logic             feed_evt,
  input  logic             clr_evt,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [CNT_W-1:0] rld_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             en,
  output logic             running,
  output logic             ew_flag,
  output logic             irq,
  output logic             rst_pulse
);

  localparam int unsigned DIV_W = MAX_CODE + 2;

  logic [DIV_W-1:0] prediv_q, div_last;
  logic [DIV_W:0]   span;
  logic [CNT_W-1:0] cnt_q, cnt_dn;
  logic             running_q, flag_q, pulse_q;
  logic             load, tick, expire, hit;

  always_comb begin
    span     = (DIV_W+1)'(1) << kwd_div_shift(8'(pre_code), MAX_CODE);
    div_last = DIV_W'(span - (DIV_W+1)'(1));
  end

  assign load   = go_evt || feed_evt;
  assign tick   = running_q && (prediv_q == div_last);
  assign cnt_dn = cnt_q - CNT_W'(1);
  assign expire = tick && (cnt_q == '0) && !load;
  assign hit    = tick && (cnt_q != '0) && (cnt_dn == cmp_val) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      prediv_q  <= '0;
      cnt_q     <= '1;
    end else begin
      if (go_evt) running_q <= 1'b1;
      if (load) begin
        prediv_q <= '0;
        cnt_q    <= rld_val;
      end else if (tick) begin
        prediv_q <= '0;
        cnt_q    <= (cnt_q == '0) ? rld_val : cnt_dn;
      end else if (running_q) begin
        prediv_q <= prediv_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire;
      if (hit)          flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
    end
  end

  assign running   = running_q;
  assign ew_flag   = flag_q;
  assign irq       = flag_q && en;
  assign rst_pulse = pulse_q;

  // R5: the reset request lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  // R4: nothing but reset stops the watchdog
  a_r4_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> running_q);

  // R6: a feed or start loads the reload value
  a_r6_feed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(rld_val)));

  // R5: a tick above zero steps the counter down by one
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R10: an acknowledge without a new crossing clears the flag
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !hit) |=> !ew_flag);

endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W        = 12,
  parameter int unsigned PRE_W        = 4,
  parameter int unsigned PRE_MAX_CODE = 8,
  parameter int unsigned SYNC_LAT     = 5,
  parameter logic [7:0]  REV          = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdg_irq,
  output logic        wdg_reset_pulse
);

  logic [PRE_W-1:0] pre_eff;
  logic [CNT_W-1:0] rld_eff, cmp_eff;
  logic             en_eff, feed_evt, go_evt, clr_evt, running, ew_flag;

  kwd_regfile #(
    .CNT_W    (CNT_W),
    .PRE_W    (PRE_W),
    .SYNC_LAT (SYNC_LAT),
    .REV      (REV)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .running  (running),
    .ew_flag  (ew_flag),
    .pre_eff  (pre_eff),
    .rld_eff  (rld_eff),
    .cmp_eff  (cmp_eff),
    .en_eff   (en_eff),
    .feed_evt (feed_evt),
    .go_evt   (go_evt),
    .clr_evt  (clr_evt)
  );

  kwd_counter #(
    .CNT_W    (CNT_W),
    .PRE_W    (PRE_W),
    .MAX_CODE (PRE_MAX_CODE)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_evt    (go_evt),
    .feed_evt  (feed_evt),
    .clr_evt   (clr_evt),
    .pre_code  (pre_eff),
    .rld_val   (rld_eff),
    .cmp_val   (cmp_eff),
    .en        (en_eff),
    .running   (running),
    .ew_flag   (ew_flag),
    .irq       (wdg_irq),
    .rst_pulse (wdg_reset_pulse)
  );

  // R7: the interrupt never shows without the early-warning flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_irq |-> ew_flag);

endmodule

// File: tb/kwd_watchdog_test.sv
module kwd_watchdog_test;

  localparam int LAT = 5;
  localparam logic [11:0] A_KEY = 12'h000, A_PRE = 12'h004, A_RLD = 12'h008,
                          A_STAT = 12'h00C, A_EWC = 12'h014, A_ICLR = 12'h018,
                          A_VER = 12'h3F4;
  // {divider code, reload, compare}
  localparam int VEC [0:4][0:2] = '{'{0, 10, 6}, '{1, 7, 2}, '{2, 4, 0},
                                    '{9, 3, 1}, '{3, 12, 11}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdg_irq, wdg_reset_pulse;
  int          cyc = 0;
  int          nchk = 0;
  int          nbad = 0;
  bit          finished = 1'b0;

  kwd_watchdog uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr_en       (bus_wr_en),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .wdg_irq         (wdg_irq),
    .wdg_reset_pulse (wdg_reset_pulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      #1;
      if (wdg_reset_pulse) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      #1;
      if (wdg_irq) begin
        at = cyc;
        break;
      end
    end
  endtask

  function automatic int divisor(input int code);
    return 4 << ((code > 8) ? 8 : code);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int v, s, t, p, d;
    do_reset();

    // R1 / R11: reset view
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_PRE, v);  chk("R1 divider", v, 0);
    rd(A_RLD, v);  chk("R1 reload", v, 32'hFFF);
    rd(A_EWC, v);  chk("R1 early word", v, 0);
    chk("R1 outputs", {wdg_irq, wdg_reset_pulse}, 0);
    rd(A_VER, v);  chk("R11 revision", v, 32'h40);
    rd(A_KEY, v);  chk("R11 key reads 0", v, 0);
    rd(A_ICLR, v); chk("R11 clear reg reads 0", v, 0);

    // R2: locked writes ignored
    wr(A_PRE, 3); wr(A_RLD, 7); wr(A_EWC, 32'h8005);
    rd(A_PRE, v); chk("R2 locked divider", v, 0);
    rd(A_RLD, v); chk("R2 locked reload", v, 32'hFFF);
    rd(A_EWC, v); chk("R2 locked early word", v, 0);
    rd(A_STAT, v); chk("R2 no busy", v, 0);
    wr(A_KEY, 32'h5555); wr(A_KEY, 32'h1234); wr(A_PRE, 3);
    rd(A_PRE, v); chk("R2 relocked by other key", v, 0);

    // R3: busy window
    wr(A_KEY, 32'h5555);
    wr(A_RLD, 32'h123);
    bus_addr = A_STAT;
    #1 chk("R3 reload busy at once", int'(bus_rdata[1]), 1);
    for (int k = 1; k <= LAT; k++) begin
      @(posedge clk);
      #1 chk("R3 reload busy window", int'(bus_rdata[1]), (k < LAT) ? 1 : 0);
    end
    rd(A_RLD, v); chk("R3 reload readback", v, 32'h123);
    wr(A_PRE, 2);
    rd(A_STAT, v); chk("R3 divider busy", v & 15, 1);
    repeat (LAT + 1) @(posedge clk);
    wr(A_EWC, 32'h8003);
    rd(A_STAT, v); chk("R3 early busy pair", v & 15, 12);

    // R5 / R7: table of timing vectors
    for (int n = 0; n < 5; n++) begin
      do_reset();
      d = divisor(VEC[n][0]);
      wr(A_KEY, 32'h5555);
      wr(A_PRE, VEC[n][0]);
      wr(A_RLD, VEC[n][1]);
      wr(A_EWC, 32'h8000 | VEC[n][2]);
      repeat (LAT + 2) @(posedge clk);
      wr(A_KEY, 32'hCCCC);
      s = cyc;
      wait_irq(t);
      chk("R7 irq delay", t - s, (VEC[n][1] - VEC[n][2]) * d);
      wait_pulse(p);
      chk("R5 pulse delay", p - s, (VEC[n][1] + 1) * d);
      @(posedge clk);
      #1 chk("R5 pulse one cycle", int'(wdg_reset_pulse), 0);
    end

    // R3: a still-busy reload is not used
    do_reset();
    wr(A_KEY, 32'h5555);
    wr(A_RLD, 20);
    repeat (LAT + 2) @(posedge clk);
    wr(A_RLD, 3);
    wr(A_KEY, 32'hCCCC);
    s = cyc;
    wait_pulse(p);
    chk("R3 old reload in use", p - s, 21 * 4);

    // R4 R6 R8 R9 R10 scenario
    do_reset();
    wr(A_KEY, 32'h5555);
    wr(A_RLD, 10);
    wr(A_EWC, 32'h8006);
    repeat (LAT + 2) @(posedge clk);
    wr(A_KEY, 32'hCCCC);
    s = cyc;
    rd(A_STAT, v); chk("R4 running bit", (v >> 8) & 1, 1);
    wait_irq(t);
    chk("R7 irq in scenario", t - s, 16);
    rd(A_STAT, v); chk("R7 flag bit 15", (v >> 15) & 1, 1);
    wr(A_EWC, 32'hC002);
    #1 chk("R9 locked ack drops irq", int'(wdg_irq), 0);
    rd(A_EWC, v); chk("R9 locked keeps early word", v, 32'h8006);
    rd(A_STAT, v); chk("R9 no busy from locked write", v & 15, 0);
    wait_pulse(p);
    chk("R9 locked write did not feed", p - s, 44);
    wait_irq(t);
    chk("R5 counting resumes after pulse", t - p, 16);
    wr(A_ICLR, 32'h8000);
    #1 chk("R10 clear drops irq", int'(wdg_irq), 0);
    rd(A_STAT, v); chk("R10 flag bit cleared", (v >> 15) & 1, 0);
    wr(A_KEY, 32'h5555);
    wr(A_EWC, 32'h8006);
    s = cyc;
    wait_pulse(p);
    chk("R8 early write feeds", p - s, 44);
    repeat (10) @(posedge clk);
    wr(A_KEY, 32'hAAAA);
    s = cyc;
    wait_pulse(p);
    chk("R6 feed key restarts", p - s, 44);
    wr(A_KEY, 32'h0000);
    wr(A_KEY, 32'h1111);
    wr(A_ICLR, 32'hFFFF);
    rd(A_STAT, v); chk("R4 cannot be stopped", (v >> 8) & 1, 1);
    do_reset();
    rd(A_STAT, v); chk("R4 reset stops", v, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule